// File: doc/BRIEF.md
# Branch target landing-pad checker

This block sits in the decode or retire stage of an in-order core and enforces landing-pad discipline for indirect branches. Every valid instruction is presented with its 32-bit word, a flag that says whether its fetch address lies in guarded memory, the current 2-bit branch-type state, and the branch type this instruction itself produces. The block decodes a dedicated hint encoding (the landing pad), whose 2-bit operand names the kinds of indirect branch that may arrive on it. It checks that operand against the branch-type state.

Inside guarded memory, when the branch-type state is nonzero, only a compatible landing pad or an always-allowed instruction may run. The always-allowed instructions are breakpoint, halt and the two return-address signing hints. Any other instruction raises a branch-target exception. The block registers three results: the exception flag, the branch-type state for the next instruction, and a flag saying the instruction decoded as a landing pad. All three change only on a cycle with the instruction-valid strobe high.

Top module: `lp_guard_check`

## Requirements
- R1: After reset, all three outputs (`bt_exc_q`, `btype_next_q`, `is_pad_q`) are 0.
- R2: An instruction is a landing pad when bits [31:8] equal 0xD50324, bit 5 is 0 and bits [4:0] are 0b11111. Bits [7:6] are its target operand. `is_pad_q` shows this one cycle after the valid strobe. The same word with bit 5 set is not a pad.
- R3: A branch-type state of 00 never raises an exception, whatever the instruction.
- R4: An instruction outside guarded memory never raises an exception. A landing pad there acts as a no-operation, and the next state is the supplied branch type.
- R5: Inside guarded memory with a nonzero state, an instruction that is neither a compatible pad nor always-allowed raises `bt_exc_q`.
- R6: Pad compatibility with a nonzero state works as follows. Operand 00 matches no state. Operand 01 (call) matches states 01 and 10. Operand 10 (jump) matches states 01 and 11. Operand 11 matches all three nonzero states.
- R7: Four encodings never raise an exception. Breakpoint is bits [31:21]=0xD4 followed by 001 with bits [4:0]=0. Halt is bits [31:21]=0xD4 followed by 010 with bits [4:0]=0. The two signing hints are 0xD503233F and 0xD503237F.
- R8: The next state is 00 when an exception is raised, and also for a landing pad inside guarded memory. Otherwise the next state equals the supplied branch type.
- R9: While the valid strobe is low, all three outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction present this cycle |
| instr | input | 32 | Instruction word |
| guarded | input | 1 | Fetch address lies in guarded memory |
| btype_cur | input | 2 | Current branch-type state |
| btype_branch | input | 2 | Branch type this instruction produces (00 if not a branch) |
| bt_exc_q | output | 1 | Branch-target exception, registered |
| btype_next_q | output | 2 | Next branch-type state, registered |
| is_pad_q | output | 1 | Instruction decoded as a landing pad, registered |

## Verification
Each result is due at the first rising edge after the cycle in which the valid strobe is high, because one register stands between the inputs and every output. The bench applies inputs at the falling edge and compares 1 ns after the next rising edge against a bench model. After a cycle with the strobe low, the bench checks that all three outputs still hold the previous values.

// File: rtl/lp_pkg.sv
package lp_pkg;
    localparam int INSTR_W = 32;
    localparam int BT_W    = 2;

    localparam logic [23:0] PAD_HI      = 24'hD50324;
    localparam logic [4:0]  HINT_LO     = 5'b11111;
    localparam logic [19:0] HINT_HI20   = 20'hD5032;
    localparam logic [3:0]  SIGN_CRM    = 4'b0011;
    localparam logic [7:0]  EXC_CLASS   = 8'hD4;
    localparam logic [2:0]  OPC_BRK     = 3'b001;
    localparam logic [2:0]  OPC_HLT     = 3'b010;

    typedef struct packed {
        logic            exc;
        logic [BT_W-1:0] bt;
        logic            pad;
    } lp_out_t;
endpackage

// File: rtl/lp_decode.sv
module lp_decode
    import lp_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic               is_pad,
    output logic [1:0]         pad_tgt,
    output logic               is_brk,
    output logic               is_hlt,
    output logic               is_sign
);
    logic       hint_space;
    logic [2:0] op2;

    always_comb begin
        op2        = instr[7:5];
        hint_space = (instr[31:12] == HINT_HI20) && (instr[4:0] == HINT_LO);
        is_pad     = (instr[31:8] == PAD_HI) && !instr[5] && (instr[4:0] == HINT_LO);
        pad_tgt    = instr[7:6];
        is_sign    = hint_space && (instr[11:8] == SIGN_CRM) &&
                     ((op2 == 3'b001) || (op2 == 3'b011));
        is_brk     = (instr[31:24] == EXC_CLASS) && (instr[23:21] == OPC_BRK) &&
                     (instr[4:0] == 5'b00000);
        is_hlt     = (instr[31:24] == EXC_CLASS) && (instr[23:21] == OPC_HLT) &&
                     (instr[4:0] == 5'b00000);
    end
endmodule

// File: rtl/lp_compat.sv
module lp_compat
    import lp_pkg::*;
(
    input  logic [1:0]      tgt,
    input  logic [BT_W-1:0] state,
    output logic            ok
);
    always_comb begin
        unique case (tgt)
            2'b00:   ok = 1'b0;
            2'b01:   ok = (state == 2'b01) || (state == 2'b10);
            2'b10:   ok = (state == 2'b01) || (state == 2'b11);
            default: ok = (state != 2'b00);
        endcase
    end
endmodule

// File: rtl/lp_guard_check.sv
module lp_guard_check
    import lp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               instr_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               guarded,
    input  logic [BT_W-1:0]    btype_cur,
    input  logic [BT_W-1:0]    btype_branch,
    output logic               bt_exc_q,
    output logic [BT_W-1:0]    btype_next_q,
    output logic               is_pad_q
);
    logic       dec_pad, dec_brk, dec_hlt, dec_sign, pad_ok;
    logic [1:0] dec_tgt;
    logic       allowed, exc_now;
    lp_out_t    out_d, out_q;

    lp_decode u_dec (
        .instr   (instr),
        .is_pad  (dec_pad),
        .pad_tgt (dec_tgt),
        .is_brk  (dec_brk),
        .is_hlt  (dec_hlt),
        .is_sign (dec_sign)
    );

    lp_compat u_cmp (
        .tgt   (dec_tgt),
        .state (btype_cur),
        .ok    (pad_ok)
    );

    always_comb begin
        allowed = (dec_pad && pad_ok) || dec_brk || dec_hlt || dec_sign;
        exc_now = guarded && (btype_cur != '0) && !allowed;
        out_d   = out_q;
        if (instr_valid) begin
            out_d.exc = exc_now;
            out_d.pad = dec_pad;
            if (exc_now || (dec_pad && guarded))
                out_d.bt = '0;
            else
                out_d.bt = btype_branch;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign bt_exc_q     = out_q.exc;
    assign btype_next_q = out_q.bt;
    assign is_pad_q     = out_q.pad;

    assert_decode_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_pad, dec_brk, dec_hlt, dec_sign}));

    assert_zero_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && btype_cur == 2'b00) |=> !bt_exc_q);

    assert_unguarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !guarded) |=> !bt_exc_q);

    assert_exc_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bt_exc_q |-> (btype_next_q == 2'b00));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> ($stable(bt_exc_q) && $stable(btype_next_q) && $stable(is_pad_q)));
endmodule

// File: tb/lp_guard_check_tb.sv
module lp_guard_check_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = 32'h0;
    logic        guarded = 1'b0;
    logic [1:0]  btype_cur = 2'b00;
    logic [1:0]  btype_branch = 2'b00;
    logic        bt_exc_q;
    logic [1:0]  btype_next_q;
    logic        is_pad_q;

    int n_chk = 0;
    int n_bad = 0;
    logic       e_exc = 1'b0;
    logic [1:0] e_bt  = 2'b00;
    logic       e_pad = 1'b0;

    always #10 clk = ~clk;

    lp_guard_check u_dut (
        .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
        .guarded(guarded), .btype_cur(btype_cur), .btype_branch(btype_branch),
        .bt_exc_q(bt_exc_q), .btype_next_q(btype_next_q), .is_pad_q(is_pad_q)
    );

    function automatic logic m_pad(input logic [31:0] w);
        return (w[31:8] == 24'hD50324) && (w[5] == 1'b0) && (w[4:0] == 5'h1F);
    endfunction

    function automatic logic m_free(input logic [31:0] w);
        logic brk, hlt, sgn;
        brk = (w[31:21] == 11'b11010100_001) && (w[4:0] == 5'd0);
        hlt = (w[31:21] == 11'b11010100_010) && (w[4:0] == 5'd0);
        sgn = (w == 32'hD503233F) || (w == 32'hD503237F);
        return brk || hlt || sgn;
    endfunction

    function automatic logic m_match(input logic [1:0] t, input logic [1:0] s);
        case (t)
            2'b00:   return 1'b0;
            2'b01:   return s == 2'b01 || s == 2'b10;
            2'b10:   return s == 2'b01 || s == 2'b11;
            default: return s != 2'b00;
        endcase
    endfunction

    task automatic check(input string req);
        n_chk++;
        if (bt_exc_q !== e_exc || btype_next_q !== e_bt || is_pad_q !== e_pad) begin
            n_bad++;
            $display("FAIL %s: got exc=%b bt=%b pad=%b expected exc=%b bt=%b pad=%b",
                     req, bt_exc_q, btype_next_q, is_pad_q, e_exc, e_bt, e_pad);
        end
    endtask

    task automatic step(input logic v, input logic [31:0] w, input logic g,
                        input logic [1:0] s, input logic [1:0] b, input string req);
        logic x;
        @(negedge clk);
        instr_valid = v; instr = w; guarded = g; btype_cur = s; btype_branch = b;
        if (v) begin
            x = g && (s != 2'b00) && !((m_pad(w) && m_match(w[7:6], s)) || m_free(w));
            e_exc = x;
            e_pad = m_pad(w);
            e_bt  = (x || (m_pad(w) && g)) ? 2'b00 : b;
        end
        @(posedge clk);
        #1;
        check(req);
    endtask

    function automatic logic [31:0] padw(input logic [1:0] t);
        return {24'hD50324, t, 1'b0, 5'h1F};
    endfunction

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog: got hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [1:0]  s, b;
        logic        g, v;
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R2 pad decode and bit-5 near miss
        step(1, padw(2'b10), 0, 2'b00, 2'b00, "R2 pad");
        step(1, padw(2'b10) | 32'h20, 0, 2'b00, 2'b00, "R2 bit5 set");
        // R6 full compatibility table
        for (int t = 0; t < 4; t++)
            for (int st = 1; st < 4; st++)
                step(1, padw(t[1:0]), 1, st[1:0], 2'b00, "R6 table");
        // R3 zero state, arbitrary instruction
        step(1, 32'h8B020020, 1, 2'b00, 2'b10, "R3 zero state");
        // R4 unguarded pad keeps supplied type
        step(1, padw(2'b00), 0, 2'b11, 2'b01, "R4 unguarded");
        // R5 plain instruction in guarded memory
        step(1, 32'h8B020020, 1, 2'b10, 2'b01, "R5 illegal target");
        // R7 allowed set
        step(1, 32'hD4200000 | (32'h1234 << 5), 1, 2'b11, 2'b00, "R7 brk");
        step(1, 32'hD4400000 | (32'h0042 << 5), 1, 2'b01, 2'b00, "R7 hlt");
        step(1, 32'hD503233F, 1, 2'b10, 2'b00, "R7 sign a");
        step(1, 32'hD503237F, 1, 2'b11, 2'b00, "R7 sign b");
        step(1, 32'hD503235F, 1, 2'b11, 2'b00, "R7 near miss");
        // R8 branch type passthrough
        step(1, 32'hD61F0200, 1, 2'b00, 2'b11, "R8 passthrough");
        // R9 hold with strobe low
        step(0, 32'h8B020020, 1, 2'b10, 2'b01, "R9 hold");
        step(0, padw(2'b11), 0, 2'b00, 2'b00, "R9 hold");

        for (int i = 0; i < 3000; i++) begin
            case ($urandom_range(0, 5))
                0, 1:    w = padw(2'($urandom_range(0, 3))) | (($urandom_range(0, 3) == 0) ? 32'h20 : 32'h0);
                2:       w = 32'hD4000000 | (32'($urandom_range(1, 2)) << 21) | (32'($urandom_range(0, 65535)) << 5);
                3:       w = ($urandom_range(0, 1) != 0) ? 32'hD503233F : 32'hD503237F;
                default: w = $urandom();
            endcase
            g = 1'($urandom_range(0, 3) != 0);
            s = 2'($urandom_range(0, 3));
            b = 2'($urandom_range(0, 3));
            v = 1'($urandom_range(0, 7) != 0);
            step(v, w, g, s, b, "R8 random");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule